// File: doc/BRIEF.md
# Processor Status and Exception Backup Registers

This block holds the architectural status state of a 32-bit core. It contains a status word with three live mode bits (stack select, interrupt enable, carry) and three backup copies of them, a read-only condition register that mirrors the carry bit, two banked stack pointers, of which one at a time is visible as general register 15, and a backup program counter used for exception return.

The core reaches it through a control-register port addressed by a small register number, with a combinational read and a write committed at the clock edge. A separate register-15 port gives the register file access to the stack pointer the stack select bit currently picks. A bit-modify port sets or clears chosen mode bits. An exception-entry strobe saves the mode bits and a program counter and moves the core to the interrupt stack with interrupts off. A return strobe restores the mode bits. The aligned return address is always presented on an output.

When several of these events fall in the same cycle, a fixed priority decides which one acts. Reset is synchronous and active-low.

Top module: `cpu_status_regs`

## Requirements
- R1: Control register 0 holds carry at bit 0, interrupt enable at bit 6, stack select at bit 7, backup carry at bit 8, backup interrupt enable at bit 14 and backup stack select at bit 15. A write loads those six bits from the same positions of the write data. Every other bit reads 0 whatever was written.
- R2: After reset the live stack select, interrupt enable and carry bits read 0. The backup bits carry no reset guarantee.
- R3: On exception entry, each backup bit takes the value its live bit had before the entry. Live stack select and live interrupt enable become 0. Live carry keeps its value.
- R4: Register-15 reads and writes reach the interrupt stack pointer when live stack select is 0 and the user stack pointer when it is 1. The select is the value held before the clock edge.
- R5: Control register 1 reads as the live carry bit in bit 0 with 0 in bits 31..1. Writes to it change nothing.
- R6: On exception entry the backup PC loads the next-instruction PC when the resume-next input is 1, and the faulting PC when it is 0. Bit 0 is stored as 0, on entry and on a write to control register 6.
- R7: The resume PC output always equals the backup PC with bits 1..0 forced to 00.
- R8: On return from exception the live bits load from their backup bits. The backup bits keep their values.
- R9: The bit-modify port takes an 8-bit mask over bits 7..0 of the status word. With set=1 it forces the masked bits to 1, with set=0 to 0. Only mask bits 0, 6 and 7 have any effect, and backup bits never change.
- R10: Control register 2 reads and writes the interrupt stack pointer and control register 3 the user stack pointer, whatever the value of stack select.
- R11: Control register numbers 4, 5 and 7 read as 0, and writes to them change no state.
- R12: When events coincide on the status bits, exception entry beats return, return beats a control register 0 write, and that write beats the bit-modify port. A control-register write to a stack pointer beats a register-15 write to the same pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cr_we | input | 1 | Control-register write strobe |
| cr_sel | input | CRN_W (3) | Control register number |
| cr_wdata | input | XLEN (32) | Control-register write data |
| cr_rdata | output | XLEN (32) | Control-register read data (combinational) |
| r15_we | input | 1 | Register-15 write strobe |
| r15_wdata | input | XLEN (32) | Register-15 write data |
| r15_rdata | output | XLEN (32) | Currently selected stack pointer |
| psw_mod_en | input | 1 | Bit-modify strobe |
| psw_mod_set | input | 1 | 1 sets, 0 clears the masked bits |
| psw_mod_mask | input | 8 | Bit mask over status bits 7..0 |
| exc_enter | input | 1 | Exception entry strobe |
| exc_resume_next | input | 1 | 1 saves next PC, 0 saves faulting PC |
| exc_fault_pc | input | XLEN (32) | PC of the faulting instruction |
| exc_next_pc | input | XLEN (32) | PC of the following instruction |
| exc_return | input | 1 | Return-from-exception strobe |
| resume_pc | output | XLEN (32) | Word-aligned return address |

## Verification
The bench sweeps all 64 combinations of the six status bits with noise in the unused positions. A design with a misplaced or leaking bit would return the noise or a shifted pattern. It applies all 256 modify masks in both directions from both extreme states, which catches a design that touches backup bits or honours mask bits 1 to 5. Exception entry is driven from all eight live-bit states with both PC selections and odd, misaligned PCs. That exposes a design that copies the bits after clearing them, clears carry, keeps bit 0 of the saved PC or leaves bits 1..0 in the return address. Coincident strobes and the use of the stack select held before the edge for register 15 are checked explicitly, because a design with a swapped priority or a look-ahead select writes the wrong stack pointer.

// File: rtl/status_regs_pkg.sv
// Package: shared layout constants and types for the status register block.
// Assumes a status word whose meaningful bits all sit in the low 16 bits.
package status_regs_pkg;

    // Bit positions inside the status word (neighbouring logic decodes these).
    localparam int POS_C   = 0;
    localparam int POS_IE  = 6;
    localparam int POS_SM  = 7;
    localparam int POS_BC  = 8;
    localparam int POS_BIE = 14;
    localparam int POS_BSM = 15;

    // Control register numbers.
    localparam int CRID_STATUS = 0;
    localparam int CRID_COND   = 1;
    localparam int CRID_ISP    = 2;
    localparam int CRID_USP    = 3;
    localparam int CRID_BKPC   = 6;

    // Stack bank indices.
    localparam int BANK_ISP = 0;
    localparam int BANK_USP = 1;
    localparam int NUM_BANKS = 2;

    // One set of mode bits, used for the live and the backup field.
    typedef struct packed {
        logic sm;
        logic ie;
        logic c;
    } mode_bits_t;

    // Assemble the 16-bit status image from live and backup fields.
    function automatic logic [15:0] pack_status(mode_bits_t live, mode_bits_t bkup);
        logic [15:0] img;
        img          = '0;
        img[POS_C]   = live.c;
        img[POS_IE]  = live.ie;
        img[POS_SM]  = live.sm;
        img[POS_BC]  = bkup.c;
        img[POS_BIE] = bkup.ie;
        img[POS_BSM] = bkup.sm;
        return img;
    endfunction

endpackage

// File: rtl/status_word.sv
// Module: status_word
// Holds the live and backup mode bits. Resolves coincident events by fixed
// priority: exception entry, then return, then a register write, then the
// bit-modify port. Assumes the caller has already decoded the register
// write strobe and extracted the six meaningful bits of the write data.
module status_word
    import status_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_i,
    input  logic       return_i,
    input  logic       wr_en_i,
    input  mode_bits_t wr_live_i,
    input  mode_bits_t wr_bkup_i,
    input  logic       mod_en_i,
    input  logic       mod_set_i,
    input  mode_bits_t mod_mask_i,
    output mode_bits_t live_o,
    output mode_bits_t bkup_o
);

    mode_bits_t live_q, live_d;
    mode_bits_t bkup_q, bkup_d;

    // Next-state selection by event priority.
    always_comb begin
        live_d = live_q;
        bkup_d = bkup_q;
        if (enter_i) begin
            bkup_d    = live_q;
            live_d.sm = 1'b0;
            live_d.ie = 1'b0;
        end else if (return_i) begin
            live_d = bkup_q;
        end else if (wr_en_i) begin
            live_d = wr_live_i;
            bkup_d = wr_bkup_i;
        end else if (mod_en_i) begin
            if (mod_set_i) begin
                live_d = live_q | mod_mask_i;
            end else begin
                live_d = live_q & ~mod_mask_i;
            end
        end
    end

    // State registers; backups are cleared too so simulation carries no X.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            bkup_q <= '0;
        end else begin
            live_q <= live_d;
            bkup_q <= bkup_d;
        end
    end

    assign live_o = live_q;
    assign bkup_o = bkup_q;

endmodule

// File: rtl/stack_bank.sv
// Module: stack_bank
// Two banked stack pointers. Each is reachable directly through its own
// control-register strobe, or through register 15 when the select bit
// picks it. A direct write beats a register-15 write to the same bank.
// Assumes the select input is the registered stack select bit.
module stack_bank
    import status_regs_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_user_i,
    input  logic                 r15_we_i,
    input  logic [XLEN-1:0]      r15_wdata_i,
    input  logic [NUM_BANKS-1:0] dir_we_i,
    input  logic [XLEN-1:0]      dir_wdata_i,
    output logic [XLEN-1:0]      isp_o,
    output logic [XLEN-1:0]      usp_o,
    output logic [XLEN-1:0]      r15_o
);

    logic [NUM_BANKS-1:0][XLEN-1:0] sp_all;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [XLEN-1:0] sp_q;
        logic            r15_hit;

        // This bank is the register-15 target when the select bit matches it.
        assign r15_hit = r15_we_i && (sel_user_i == (b == BANK_USP));

        // Stack pointer storage with direct-write priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sp_q <= '0;
            end else if (dir_we_i[b]) begin
                sp_q <= dir_wdata_i;
            end else if (r15_hit) begin
                sp_q <= r15_wdata_i;
            end
        end

        assign sp_all[b] = sp_q;
    end

    assign isp_o = sp_all[BANK_ISP];
    assign usp_o = sp_all[BANK_USP];

    // Register-15 view follows the current select bit.
    always_comb begin
        r15_o = sel_user_i ? sp_all[BANK_USP] : sp_all[BANK_ISP];
    end

endmodule

// File: rtl/backup_pc.sv
// Module: backup_pc
// Saves a program counter on exception entry (fault or next PC by type)
// and also accepts a control-register write. Bit 0 is never stored as 1.
// Presents the word-aligned return address at all times. Entry beats a
// register write in the same cycle.
module backup_pc #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_i,
    input  logic            use_next_i,
    input  logic [XLEN-1:0] fault_pc_i,
    input  logic [XLEN-1:0] next_pc_i,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_data_i,
    output logic [XLEN-1:0] bpc_o,
    output logic [XLEN-1:0] ret_pc_o
);

    localparam logic [XLEN-1:0] LSB_CLR  = {{(XLEN-1){1'b1}}, 1'b0};
    localparam logic [XLEN-1:0] WORD_CLR = {{(XLEN-2){1'b1}}, 2'b00};

    logic [XLEN-1:0] bpc_q;
    logic [XLEN-1:0] save_pc;

    // Choose the PC to save from the exception type.
    always_comb begin
        save_pc = use_next_i ? next_pc_i : fault_pc_i;
    end

    // Backup PC storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpc_q <= '0;
        end else if (enter_i) begin
            bpc_q <= save_pc & LSB_CLR;
        end else if (wr_en_i) begin
            bpc_q <= wr_data_i & LSB_CLR;
        end
    end

    assign bpc_o    = bpc_q;
    assign ret_pc_o = bpc_q & WORD_CLR;

endmodule

// File: rtl/cpu_status_regs.sv
// Module: cpu_status_regs (top)
// Status word with backup field, read-only carry mirror, banked stack
// pointers behind register 15, and backup PC. Decodes the control-register
// port, routes strobes to the three storage units and muxes read data.
// Assumes the core never relies on the contents of unused register numbers.
module cpu_status_regs
    import status_regs_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CRN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cr_we,
    input  logic [CRN_W-1:0] cr_sel,
    input  logic [XLEN-1:0]  cr_wdata,
    output logic [XLEN-1:0]  cr_rdata,
    input  logic             r15_we,
    input  logic [XLEN-1:0]  r15_wdata,
    output logic [XLEN-1:0]  r15_rdata,
    input  logic             psw_mod_en,
    input  logic             psw_mod_set,
    input  logic [7:0]       psw_mod_mask,
    input  logic             exc_enter,
    input  logic             exc_resume_next,
    input  logic [XLEN-1:0]  exc_fault_pc,
    input  logic [XLEN-1:0]  exc_next_pc,
    input  logic             exc_return,
    output logic [XLEN-1:0]  resume_pc
);

    localparam logic [CRN_W-1:0] SEL_STATUS = CRN_W'(CRID_STATUS);
    localparam logic [CRN_W-1:0] SEL_COND   = CRN_W'(CRID_COND);
    localparam logic [CRN_W-1:0] SEL_ISP    = CRN_W'(CRID_ISP);
    localparam logic [CRN_W-1:0] SEL_USP    = CRN_W'(CRID_USP);
    localparam logic [CRN_W-1:0] SEL_BKPC   = CRN_W'(CRID_BKPC);

    mode_bits_t           live_q, bkup_q;
    mode_bits_t           wr_live, wr_bkup, mod_mask;
    logic                 we_status, we_bkpc;
    logic [NUM_BANKS-1:0] we_sp;
    logic [XLEN-1:0]      isp_q, usp_q, bpc_q;
    logic [4:0]           unused_mask_bits;

    // Decode the control-register write strobes.
    always_comb begin
        we_status          = cr_we && (cr_sel == SEL_STATUS);
        we_bkpc            = cr_we && (cr_sel == SEL_BKPC);
        we_sp              = '0;
        we_sp[BANK_ISP]    = cr_we && (cr_sel == SEL_ISP);
        we_sp[BANK_USP]    = cr_we && (cr_sel == SEL_USP);
    end

    // Extract the meaningful status bits from write data and modify mask.
    always_comb begin
        wr_live.c   = cr_wdata[POS_C];
        wr_live.ie  = cr_wdata[POS_IE];
        wr_live.sm  = cr_wdata[POS_SM];
        wr_bkup.c   = cr_wdata[POS_BC];
        wr_bkup.ie  = cr_wdata[POS_BIE];
        wr_bkup.sm  = cr_wdata[POS_BSM];
        mod_mask.c  = psw_mod_mask[POS_C];
        mod_mask.ie = psw_mod_mask[POS_IE];
        mod_mask.sm = psw_mod_mask[POS_SM];
    end

    // Mask positions 1..5 name no status bit and are dropped.
    assign unused_mask_bits = psw_mod_mask[5:1];

    status_word u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_i    (exc_enter),
        .return_i   (exc_return),
        .wr_en_i    (we_status),
        .wr_live_i  (wr_live),
        .wr_bkup_i  (wr_bkup),
        .mod_en_i   (psw_mod_en),
        .mod_set_i  (psw_mod_set),
        .mod_mask_i (mod_mask),
        .live_o     (live_q),
        .bkup_o     (bkup_q)
    );

    stack_bank #(.XLEN(XLEN)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_user_i  (live_q.sm),
        .r15_we_i    (r15_we),
        .r15_wdata_i (r15_wdata),
        .dir_we_i    (we_sp),
        .dir_wdata_i (cr_wdata),
        .isp_o       (isp_q),
        .usp_o       (usp_q),
        .r15_o       (r15_rdata)
    );

    backup_pc #(.XLEN(XLEN)) u_bkpc (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_i    (exc_enter),
        .use_next_i (exc_resume_next),
        .fault_pc_i (exc_fault_pc),
        .next_pc_i  (exc_next_pc),
        .wr_en_i    (we_bkpc),
        .wr_data_i  (cr_wdata),
        .bpc_o      (bpc_q),
        .ret_pc_o   (resume_pc)
    );

    // Control-register read multiplexer; unused numbers read zero.
    always_comb begin
        cr_rdata = '0;
        case (cr_sel)
            SEL_STATUS: cr_rdata = XLEN'(pack_status(live_q, bkup_q));
            SEL_COND:   cr_rdata = XLEN'(live_q.c);
            SEL_ISP:    cr_rdata = isp_q;
            SEL_USP:    cr_rdata = usp_q;
            SEL_BKPC:   cr_rdata = bpc_q;
            default:    cr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/status_regs_chk.sv
// Module: status_regs_chk
// Temporal checks on the status register block, attached by bind.
// Assumes synchronous active-low reset; every property is disabled in reset.
module status_regs_chk
    import status_regs_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CRN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cr_we,
    input logic [CRN_W-1:0] cr_sel,
    input logic             r15_we,
    input logic [XLEN-1:0]  r15_wdata,
    input logic             psw_mod_en,
    input logic             exc_enter,
    input logic             exc_resume_next,
    input logic [XLEN-1:0]  exc_fault_pc,
    input logic [XLEN-1:0]  exc_next_pc,
    input logic             exc_return,
    input mode_bits_t       live,
    input mode_bits_t       bkup,
    input logic [XLEN-1:0]  isp,
    input logic [XLEN-1:0]  usp,
    input logic [XLEN-1:0]  bpc
);

    localparam logic [XLEN-1:0] LSB_CLR = {{(XLEN-1){1'b1}}, 1'b0};

    // R2: first cycle out of reset shows cleared live bits.
    a_r2_reset_live_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (live == 3'b000));

    // R3: entry copies the old live bits and leaves the interrupt stack selected.
    a_r3_entry_saves_bits: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (bkup == $past(live)) && !live.sm && !live.ie
                      && (live.c == $past(live.c)));

    // R8: return without coincident entry restores live from backup.
    a_r8_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter) |=> (live == $past(bkup)) && $stable(bkup));

    // R4: a register-15 write lands in the bank chosen by the prior select.
    a_r4_r15_bank_target: assert property (@(posedge clk) disable iff (!rst_n)
        (r15_we && !cr_we) |=>
            (($past(live.sm) ? usp : isp) == $past(r15_wdata)));

    // R5: writing the carry mirror register leaves the status bits alone.
    a_r5_cond_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && cr_sel == CRN_W'(CRID_COND) && !exc_enter && !exc_return
         && !psw_mod_en) |=> ($stable(live) && $stable(bkup)));

    // R6: entry saves the PC picked by the exception type with bit 0 clear.
    a_r6_entry_saves_pc: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (bpc == (($past(exc_resume_next) ? $past(exc_next_pc)
                                                       : $past(exc_fault_pc)) & LSB_CLR)));

    // R9: the bit-modify port never reaches the backup field.
    a_r9_modify_spares_backup: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_mod_en && !exc_enter && !exc_return
         && !(cr_we && cr_sel == CRN_W'(CRID_STATUS))) |=> $stable(bkup));

    // R11: writes to unused numbers leave stack pointers and backup PC alone.
    a_r11_unused_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && (cr_sel == CRN_W'(4) || cr_sel == CRN_W'(5) || cr_sel == CRN_W'(7))
         && !r15_we && !exc_enter) |=> ($stable(isp) && $stable(usp) && $stable(bpc)));

endmodule

bind cpu_status_regs status_regs_chk #(.XLEN(XLEN), .CRN_W(CRN_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cr_we           (cr_we),
    .cr_sel          (cr_sel),
    .r15_we          (r15_we),
    .r15_wdata       (r15_wdata),
    .psw_mod_en      (psw_mod_en),
    .exc_enter       (exc_enter),
    .exc_resume_next (exc_resume_next),
    .exc_fault_pc    (exc_fault_pc),
    .exc_next_pc     (exc_next_pc),
    .exc_return      (exc_return),
    .live            (live_q),
    .bkup            (bkup_q),
    .isp             (isp_q),
    .usp             (usp_q),
    .bpc             (bpc_q)
);

// File: tb/test_cpu_status_regs.sv
// Bench: near-exhaustive sweeps of status layout, modify masks, exception
// entry and return, stack banking, unused numbers and event priority.
module test_cpu_status_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr_we = 1'b0;
    logic [2:0]  cr_sel = '0;
    logic [31:0] cr_wdata = '0;
    logic [31:0] cr_rdata;
    logic        r15_we = 1'b0;
    logic [31:0] r15_wdata = '0;
    logic [31:0] r15_rdata;
    logic        psw_mod_en = 1'b0;
    logic        psw_mod_set = 1'b0;
    logic [7:0]  psw_mod_mask = '0;
    logic        exc_enter = 1'b0;
    logic        exc_resume_next = 1'b0;
    logic [31:0] exc_fault_pc = '0;
    logic [31:0] exc_next_pc = '0;
    logic        exc_return = 1'b0;
    logic [31:0] resume_pc;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    // Reference state computed from the requirements.
    bit          m_sm, m_ie, m_c, m_bsm, m_bie, m_bc;
    logic [31:0] m_isp, m_usp, m_bpc;

    always #10 clk = ~clk;

    cpu_status_regs i_cpu_status_regs (
        .clk(clk), .rst_n(rst_n), .cr_we(cr_we), .cr_sel(cr_sel),
        .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .r15_we(r15_we),
        .r15_wdata(r15_wdata), .r15_rdata(r15_rdata), .psw_mod_en(psw_mod_en),
        .psw_mod_set(psw_mod_set), .psw_mod_mask(psw_mod_mask),
        .exc_enter(exc_enter), .exc_resume_next(exc_resume_next),
        .exc_fault_pc(exc_fault_pc), .exc_next_pc(exc_next_pc),
        .exc_return(exc_return), .resume_pc(resume_pc)
    );

    function automatic logic [31:0] exp_psw();
        return {16'b0, m_bsm, m_bie, 5'b0, m_bc, m_sm, m_ie, 5'b0, m_c};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(int a, output logic [31:0] v);
        cr_sel = 3'(a);
        #1;
        v = cr_rdata;
    endtask

    task automatic verify_all(string req);
        logic [31:0] v;
        rd(0, v); chk(req, "cr0", v, exp_psw());
        rd(1, v); chk(req, "cr1", v, {31'b0, m_c});
        rd(2, v); chk(req, "cr2", v, m_isp);
        rd(3, v); chk(req, "cr3", v, m_usp);
        rd(6, v); chk(req, "cr6", v, m_bpc);
        chk(req, "r15", r15_rdata, m_sm ? m_usp : m_isp);
        chk(req, "resume_pc", resume_pc, {m_bpc[31:2], 2'b00});
    endtask

    task automatic model_cr(int a, logic [31:0] d);
        case (a)
            0: begin
                m_c = d[0]; m_ie = d[6]; m_sm = d[7];
                m_bc = d[8]; m_bie = d[14]; m_bsm = d[15];
            end
            2: m_isp = d;
            3: m_usp = d;
            6: m_bpc = {d[31:1], 1'b0};
            default: ;
        endcase
    endtask

    task automatic cr_write(int a, logic [31:0] d);
        cr_we = 1'b1; cr_sel = 3'(a); cr_wdata = d;
        step();
        cr_we = 1'b0;
        model_cr(a, d);
    endtask

    task automatic r15_write(logic [31:0] d);
        r15_we = 1'b1; r15_wdata = d;
        step();
        r15_we = 1'b0;
        if (m_sm) m_usp = d; else m_isp = d;
    endtask

    task automatic modify(bit set, logic [7:0] mask);
        psw_mod_en = 1'b1; psw_mod_set = set; psw_mod_mask = mask;
        step();
        psw_mod_en = 1'b0;
        if (mask[0]) m_c  = set;
        if (mask[6]) m_ie = set;
        if (mask[7]) m_sm = set;
    endtask

    task automatic model_enter(bit nxt, logic [31:0] fpc, logic [31:0] npc);
        m_bsm = m_sm; m_bie = m_ie; m_bc = m_c;
        m_sm = 1'b0; m_ie = 1'b0;
        m_bpc = (nxt ? npc : fpc) & 32'hFFFF_FFFE;
    endtask

    task automatic enter(bit nxt, logic [31:0] fpc, logic [31:0] npc);
        exc_enter = 1'b1; exc_resume_next = nxt;
        exc_fault_pc = fpc; exc_next_pc = npc;
        step();
        exc_enter = 1'b0;
        model_enter(nxt, fpc, npc);
    endtask

    task automatic leave();
        exc_return = 1'b1;
        step();
        exc_return = 1'b0;
        m_sm = m_bsm; m_ie = m_bie; m_c = m_bc;
    endtask

    function automatic logic [31:0] place(int i, logic [31:0] junk);
        logic [31:0] d;
        d = junk & ~32'h0000_C1C1;
        d[0] = i[0]; d[6] = i[1]; d[7] = i[2];
        d[8] = i[3]; d[14] = i[4]; d[15] = i[5];
        return d;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R2: live bits clear after reset; carry mirror reads zero.
        rd(0, v); chk("R2", "cr0 live bits", v & 32'h0000_00C1, 32'h0);
        rd(1, v); chk("R2", "cr1", v, 32'h0);

        // Establish known contents everywhere.
        cr_write(0, 32'h0);
        cr_write(2, 32'h0000_1000);
        cr_write(3, 32'h0000_2000);
        cr_write(6, 32'h0000_0100);
        verify_all("R10");

        // R1, R5: every combination of the six bits, with noise elsewhere.
        for (int i = 0; i < 64; i++) begin
            cr_write(0, place(i, 32'h9E37_79B9 * (i + 1)));
            rd(0, v); chk("R1", "cr0 layout", v, exp_psw());
            rd(1, v); chk("R5", "cr1 mirror", v, {31'b0, m_c});
        end

        // R5: writing the mirror register changes nothing.
        cr_write(0, 32'h0000_0001);
        cr_write(1, 32'h0000_0000);
        verify_all("R5");
        cr_write(0, 32'h0000_0000);
        cr_write(1, 32'hFFFF_FFFF);
        verify_all("R5");

        // R9: all masks, set from all-zero and clear from all-ones.
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 256; m++) begin
                cr_write(0, s[0] ? 32'h0000_4100 : 32'h0000_81C1);
                modify(s[0], 8'(m));
                rd(0, v); chk("R9", "cr0 after modify", v, exp_psw());
            end
        end

        // R3, R6, R7, R8: entry from all live states, both PC choices, then return.
        for (int k = 0; k < 16; k++) begin
            cr_write(0, place(k[2:0] | ((~k[2:0] & 7) << 3), 32'h0));
            enter(k[3], 32'h4000_0003 + 32'(k * 16), 32'h8000_0006 + 32'(k * 16));
            verify_all("R3");
            chk("R6", "bkpc bit0", resume_pc & 32'h3, 32'h0);
            leave();
            verify_all("R8");
        end

        // R7: backup PC with bits 1..0 set by a register write.
        cr_write(6, 32'hCAFE_F00F);
        verify_all("R7");

        // R4, R10: register-15 banking under both select values.
        cr_write(0, 32'h0000_0000);
        r15_write(32'h1111_0000);
        verify_all("R4");
        cr_write(0, 32'h0000_0080);
        r15_write(32'h2222_0000);
        verify_all("R4");
        cr_write(2, 32'h3333_0000);
        cr_write(3, 32'h4444_0000);
        verify_all("R10");

        // R11: unused numbers read zero and ignore writes.
        for (int a = 4; a < 8; a++) begin
            if (a == 6) continue;
            cr_write(a, 32'hFFFF_FFFF);
            rd(a, v); chk("R11", "unused read", v, 32'h0);
            verify_all("R11");
        end

        // R12: entry and return together -> entry acts.
        cr_write(0, 32'h0000_00C1);
        exc_enter = 1'b1; exc_return = 1'b1; exc_resume_next = 1'b0;
        exc_fault_pc = 32'h0000_0500; exc_next_pc = 32'h0000_0504;
        step();
        exc_enter = 1'b0; exc_return = 1'b0;
        model_enter(1'b0, 32'h0000_0500, 32'h0000_0504);
        verify_all("R12");

        // R12: return and CR0 write together -> return acts.
        cr_write(0, 32'h0000_C100);
        exc_return = 1'b1; cr_we = 1'b1; cr_sel = 3'd0; cr_wdata = 32'h0000_0000;
        step();
        exc_return = 1'b0; cr_we = 1'b0;
        m_sm = m_bsm; m_ie = m_bie; m_c = m_bc;
        verify_all("R12");

        // R12: CR0 write and modify together -> write acts.
        cr_we = 1'b1; cr_sel = 3'd0; cr_wdata = 32'h0000_0040;
        psw_mod_en = 1'b1; psw_mod_set = 1'b1; psw_mod_mask = 8'hFF;
        step();
        cr_we = 1'b0; psw_mod_en = 1'b0;
        model_cr(0, 32'h0000_0040);
        verify_all("R12");

        // R12: direct write beats register-15 write to the same bank (select 0).
        cr_we = 1'b1; cr_sel = 3'd2; cr_wdata = 32'h5555_0000;
        r15_we = 1'b1; r15_wdata = 32'h6666_0000;
        step();
        cr_we = 1'b0; r15_we = 1'b0;
        m_isp = 32'h5555_0000;
        verify_all("R12");

        // R4: register-15 write uses the select held before a same-cycle CR0 write.
        cr_we = 1'b1; cr_sel = 3'd0; cr_wdata = 32'h0000_0080;
        r15_we = 1'b1; r15_wdata = 32'h7777_0000;
        step();
        cr_we = 1'b0; r15_we = 1'b0;
        m_isp = 32'h7777_0000;
        model_cr(0, 32'h0000_0080);
        verify_all("R4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule